// File: doc/BRIEF.md
# GPIO Port with Per-Pin Function Select and Atomic Bit Updates

This block drives a 32-pin general-purpose port. For every pin it keeps one bit of output data and one bit of direction. A 2-bit function code per pin then decides where the pin's drive comes from. The code can pick the local data and direction bits, or it can pick the output and output-enable pair of one of three peripherals. The same code decides which of the three peripheral inputs receives the level seen on the pin.

Software reaches the block through a single-cycle register port. Writing the data address replaces the whole output latch. Three further addresses change only the latch bits that are written as 1: one sets them, one clears them and one inverts them. No read-modify-write sequence is needed for this. Reading the data address returns the live pin levels, not the latch contents.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset, all outputs are 0: pin_out, pin_oe, every peripheral input and both function-select registers.
- R2: The function code of pin i sits in bits [2i+1:2i] of the low select register (address 5) for pins 0 to 15. For pins 16 to 31 it sits in bits [2(i-16)+1:2(i-16)] of the high select register (address 6). Code 0 means GPIO; codes 1, 2 and 3 mean peripheral 1, 2 and 3.
- R3: A pin with code 0 drives pin_out from its data-latch bit and pin_oe from its direction bit (address 4; 1 = output, 0 = high impedance).
- R4: A pin with a non-zero code takes both pin_out and pin_oe from the selected peripheral's output and enable bits.
- R5: A write to address 0 replaces the data latch. A read of address 0 returns pin_in.
- R6: A write to address 1 sets each latch bit where the written bit is 1 and leaves the other bits unchanged.
- R7: A write to address 2 clears each latch bit where the written bit is 1 and leaves the other bits unchanged.
- R8: A write to address 3 inverts each latch bit where the written bit is 1 and leaves the other bits unchanged.
- R9: Peripheral input k, bit i, carries pin_in[i] only when pin i has code k. Otherwise it is 0.
- R10: rvalid and rdata follow rd_en by one clock. Addresses 4, 5 and 6 read back their registers. Addresses 1, 2, 3 and 7 read as 0. Writes to address 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| rvalid | output | 1 | rdata valid |
| pin_in | input | 32 | Pin levels |
| pin_out | output | 32 | Pin output data |
| pin_oe | output | 32 | Pin output enable |
| p1_out | input | 32 | Peripheral 1 output data |
| p1_oe | input | 32 | Peripheral 1 output enable |
| p1_in | output | 32 | Peripheral 1 input |
| p2_out | input | 32 | Peripheral 2 output data |
| p2_oe | input | 32 | Peripheral 2 output enable |
| p2_in | output | 32 | Peripheral 2 input |
| p3_out | input | 32 | Peripheral 3 output data |
| p3_oe | input | 32 | Peripheral 3 output enable |
| p3_in | output | 32 | Peripheral 3 input |

## Verification
A register write takes effect at the clock edge that samples it. The pin and peripheral outputs are combinational from the registers, so the new state is due at the following falling edge, and the bench checks it there. A change on pin_in or on a peripheral's output reaches the outputs with no clock at all. Read data is due exactly one rising edge after rd_en. The bench queues the expected word when it issues the read, and a monitor compares it at the next falling edge where rvalid is high.

// File: rtl/gpio_mux_port.sv
module gpio_mux_port #(
  parameter int NPIN = 32,
  parameter int AW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [NPIN-1:0] wdata,
  output logic [NPIN-1:0] rdata,
  output logic            rvalid,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe,
  input  logic [NPIN-1:0] p1_out,
  input  logic [NPIN-1:0] p1_oe,
  output logic [NPIN-1:0] p1_in,
  input  logic [NPIN-1:0] p2_out,
  input  logic [NPIN-1:0] p2_oe,
  output logic [NPIN-1:0] p2_in,
  input  logic [NPIN-1:0] p3_out,
  input  logic [NPIN-1:0] p3_oe,
  output logic [NPIN-1:0] p3_in
);
  localparam int HALF = NPIN / 2;
  localparam logic [AW-1:0] A_DATA = 3'd0;
  localparam logic [AW-1:0] A_SET  = 3'd1;
  localparam logic [AW-1:0] A_CLR  = 3'd2;
  localparam logic [AW-1:0] A_TGL  = 3'd3;
  localparam logic [AW-1:0] A_DIR  = 3'd4;
  localparam logic [AW-1:0] A_FLO  = 3'd5;
  localparam logic [AW-1:0] A_FHI  = 3'd6;

  logic [NPIN-1:0] dat_q, dir_q, fsel_lo, fsel_hi;
  logic [NPIN-1:0] rd_mux;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q   <= '0;
      dir_q   <= '0;
      fsel_lo <= '0;
      fsel_hi <= '0;
    end else if (wr_en) begin
      case (addr)
        A_DATA:  dat_q   <= wdata;
        A_SET:   dat_q   <= dat_q | wdata;
        A_CLR:   dat_q   <= dat_q & ~wdata;
        A_TGL:   dat_q   <= dat_q ^ wdata;
        A_DIR:   dir_q   <= wdata;
        A_FLO:   fsel_lo <= wdata;
        A_FHI:   fsel_hi <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      A_DATA:  rd_mux = pin_in;
      A_DIR:   rd_mux = dir_q;
      A_FLO:   rd_mux = fsel_lo;
      A_FHI:   rd_mux = fsel_hi;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rd_mux;
    end
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic [1:0] sel;
    if (i < HALF) begin : g_lo
      assign sel = fsel_lo[2*i +: 2];
    end else begin : g_hi
      assign sel = fsel_hi[2*(i-HALF) +: 2];
    end
    assign pin_out[i] = (sel == 2'd0) ? dat_q[i]  :
                        (sel == 2'd1) ? p1_out[i] :
                        (sel == 2'd2) ? p2_out[i] : p3_out[i];
    assign pin_oe[i]  = (sel == 2'd0) ? dir_q[i]  :
                        (sel == 2'd1) ? p1_oe[i]  :
                        (sel == 2'd2) ? p2_oe[i]  : p3_oe[i];
    assign p1_in[i] = (sel == 2'd1) & pin_in[i];
    assign p2_in[i] = (sel == 2'd2) & pin_in[i];
    assign p3_in[i] = (sel == 2'd3) & pin_in[i];
  end
endmodule

// File: rtl/gpio_mux_port_chk.sv
module gpio_mux_port_chk #(
  parameter int NPIN = 32,
  parameter int AW   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic            rd_en,
  input logic [AW-1:0]   addr,
  input logic [NPIN-1:0] wdata,
  input logic            rvalid,
  input logic [NPIN-1:0] dat_q,
  input logic [NPIN-1:0] fsel_lo,
  input logic [NPIN-1:0] fsel_hi,
  input logic [NPIN-1:0] pin_oe,
  input logic [NPIN-1:0] p1_in,
  input logic [NPIN-1:0] p2_in,
  input logic [NPIN-1:0] p3_in
);
  AST_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd1) |=> dat_q == ($past(dat_q) | $past(wdata))); // R6
  AST_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd2) |=> dat_q == ($past(dat_q) & ~$past(wdata))); // R7
  AST_TGL_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd3) |=> dat_q == ($past(dat_q) ^ $past(wdata))); // R8
  AST_GPIO_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd4 && fsel_lo == '0 && fsel_hi == '0) |=> pin_oe == $past(wdata)); // R3
  AST_PERIN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    ((p1_in & p2_in) | (p1_in & p3_in) | (p2_in & p3_in)) == '0); // R9
  AST_RD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid); // R10
  AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid); // R10
  AST_UNUSED_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd7) |=> $stable(dat_q)); // R10
endmodule

bind gpio_mux_port gpio_mux_port_chk #(.NPIN(NPIN), .AW(AW)) u_chk (.*);

// File: tb/sim_gpio_mux_port.sv
module sim_gpio_mux_port;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0, rdata, pin_in = '0, pin_out, pin_oe;
  logic [31:0] p1_out = 32'hA5A5_0F0F, p1_oe = 32'hFFFF_0000;
  logic [31:0] p2_out = 32'h3C3C_3C3C, p2_oe = 32'h0F0F_0F0F;
  logic [31:0] p3_out = 32'h1234_5678, p3_oe = 32'hFFFF_FFFF;
  logic [31:0] p1_in, p2_in, p3_in;
  logic rvalid;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] m_dat = 0, m_dir = 0, m_flo = 0, m_fhi = 0;
  logic [31:0] expq[$];
  string tagq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_mux_port u0 (.clk, .rst_n, .wr_en, .rd_en, .addr, .wdata, .rdata, .rvalid,
    .pin_in, .pin_out, .pin_oe, .p1_out, .p1_oe, .p1_in, .p2_out, .p2_oe, .p2_in,
    .p3_out, .p3_oe, .p3_in);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] msel(int i);
    return (i < 16) ? m_flo[2*i +: 2] : m_fhi[2*(i-16) +: 2];
  endfunction

  task automatic check_pins(string tag);
    logic [31:0] eo, ee, e1, e2, e3;
    for (int i = 0; i < 32; i++) begin
      case (msel(i))
        2'd0: begin eo[i] = m_dat[i];  ee[i] = m_dir[i]; end
        2'd1: begin eo[i] = p1_out[i]; ee[i] = p1_oe[i]; end
        2'd2: begin eo[i] = p2_out[i]; ee[i] = p2_oe[i]; end
        default: begin eo[i] = p3_out[i]; ee[i] = p3_oe[i]; end
      endcase
      e1[i] = (msel(i) == 2'd1) && pin_in[i];
      e2[i] = (msel(i) == 2'd2) && pin_in[i];
      e3[i] = (msel(i) == 2'd3) && pin_in[i];
    end
    chk({tag, " pin_out"}, pin_out, eo);
    chk({tag, " pin_oe"}, pin_oe, ee);
    chk({tag, " R9 p1_in"}, p1_in, e1);
    chk({tag, " R9 p2_in"}, p2_in, e2);
    chk({tag, " R9 p3_in"}, p3_in, e3);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    addr = a; wdata = d; wr_en = 1;
    case (a)
      3'd0: m_dat = d;
      3'd1: m_dat = m_dat | d;
      3'd2: m_dat = m_dat & ~d;
      3'd3: m_dat = m_dat ^ d;
      3'd4: m_dir = d;
      3'd5: m_flo = d;
      3'd6: m_fhi = d;
      default: ;
    endcase
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [2:0] a, logic [31:0] exp, string tag);
    expq.push_back(exp); tagq.push_back(tag);
    addr = a; rd_en = 1;
    @(negedge clk);
    rd_en = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (expq.size() == 0) chk("R10 unexpected rvalid", 32'd1, 32'd0);
      else chk(tagq.pop_front(), rdata, expq.pop_front());
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    pin_in = 32'hCAFE_F00D;
    repeat (3) @(negedge clk);
    check_pins("R1 reset");
    chk("R1 pin_out zero", pin_out, 32'h0);
    rst_n = 1;
    @(negedge clk);
    rd(3'd5, 32'h0, "R1 fsel_lo reset");
    rd(3'd6, 32'h0, "R1 fsel_hi reset");

    wr(3'd0, 32'h0000_FFFF);
    wr(3'd4, 32'h00FF_00FF);
    check_pins("R3 R5 gpio drive");
    pin_in = 32'h1357_9BDF;
    rd(3'd0, 32'h1357_9BDF, "R5 data read returns pins");

    wr(3'd1, 32'hF000_0000);
    check_pins("R6 set");
    chk("R6 latch", pin_out & pin_oe, m_dat & m_dir);
    wr(3'd1, 32'h0);
    check_pins("R6 set zero no change");
    wr(3'd2, 32'h0000_000F);
    check_pins("R7 clear");
    wr(3'd2, 32'h0);
    check_pins("R7 clear zero no change");
    wr(3'd3, 32'hFF00_FF00);
    check_pins("R8 toggle");
    wr(3'd3, 32'hFF00_FF00);
    check_pins("R8 toggle back");
    wr(3'd4, 32'hFFFF_FFFF);
    chk("R7 R8 latch via pins", pin_out, 32'hF000_FFF0);

    wr(3'd5, 32'hE4E4_E4E4);
    check_pins("R2 R4 fsel low");
    wr(3'd6, 32'h1B1B_1B1B);
    check_pins("R2 R4 fsel high");
    pin_in = 32'hFFFF_FFFF;
    #1 check_pins("R9 all ones");
    p2_out = 32'hC3C3_C3C3;
    #1 check_pins("R4 peripheral change");

    rd(3'd4, 32'hFFFF_FFFF, "R10 dir read");
    rd(3'd5, 32'hE4E4_E4E4, "R10 fsel_lo read");
    rd(3'd6, 32'h1B1B_1B1B, "R10 fsel_hi read");
    rd(3'd1, 32'h0, "R10 set reads 0");
    rd(3'd3, 32'h0, "R10 toggle reads 0");
    wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd7, 32'h0, "R10 addr7 reads 0");
    check_pins("R10 addr7 write ignored");

    wr(3'd5, 32'h0);
    wr(3'd6, 32'h0);
    check_pins("R3 back to gpio");
    chk("R9 no peripheral input", p1_in | p2_in | p3_in, 32'h0);
    wr(3'd4, 32'h0);
    chk("R3 high impedance", pin_oe, 32'h0);

    repeat (2) @(negedge clk);
    chk("R10 queue drained", expq.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule